// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Register

This block sits on the device side of a single-data-rate SDRAM interface. On every rising clock edge it captures the clock-enable, chip-select, row strobe, column strobe, write-enable, bank-select and 12-bit address pins. It turns each captured sample into at most one command strobe. It also passes through the bank, row and column fields that go with the command.

The block holds the mode-register fields: burst length, burst type, CAS latency and single-bit-write mode. It also holds the extended-register field that sets the self-refresh area. It checks the legality rules that protect those registers. Mode cycles and refresh need every bank idle, a mode cycle is followed by a short lockout, and reserved field codes are rejected. A rejected sample raises an illegal flag instead of a strobe. The block tracks which banks hold an open row. It models no array, no data path and no analog timing.

Top module: `sdcmd_decoder`

## Requirements
- R1: With CS# low and CKE high at both the previous and the current sample, the {RAS#,CAS#,WE#} code selects one strobe bit of `cmd_strb`. The codes are 000 mode cycle (bit 1 when BA=00, bit 2 when BA=10), 001 auto-refresh (bit 3), 011 activate (bit 5), 101 read (bit 6), 100 write (bit 7), 110 burst stop (bit 8), 010 precharge (bit 9) and 111 no-operation (bit 0). At most one bit is ever set.
- R2: A sample with CS# high (deselect), or one whose previous CKE sample was low, produces no strobe and no illegal flag.
- R3: The refresh code with CKE high at the previous sample and low at the current one is self-refresh entry (bit 4). Any other code with that CKE transition produces no strobe.
- R4: `cmd_bank` carries BA1:BA0, `cmd_row` carries A11:A0, `cmd_col` carries A8:A0 and `cmd_a10` carries A10 of the current sample. A10 means auto-precharge on read and write, and all banks on precharge.
- R5: An accepted activate marks its bank open. A precharge with A10 low closes the selected bank, and one with A10 high closes all banks. A read or write with A10 high closes its bank. `all_idle` reflects these changes after the edge that follows the command's sample.
- R6: An accepted normal mode cycle (BA=00) loads the fields at the following edge. `burst_len` takes A2:A0 (000=1, 001=2, 010=4, 011=8, 111=full page), `burst_intlv` takes A3 (1=interleave), `cas_lat` takes the latency from A6:A4 (001=1, 010=2, 011=3) and `wr_single` takes A9.
- R7: An accepted extended mode cycle (BA=10) loads `pasr_area` from A2:A0 (000 full array = 0, 001 half = 1, 010 quarter = 2) at the following edge.
- R8: After reset, `burst_len`=000, `burst_intlv`=0, `cas_lat`=3, `wr_single`=0, `pasr_area`=0 (full array), `all_idle`=1 and `mrs_lock`=0.
- R9: A mode cycle with a reserved burst-length code (100, 101, 110), a reserved latency code (000 or A6 high), a reserved area code (011 to 111), or bank bits 01 or 11 raises `illegal`. It then produces no strobe and leaves every stored field unchanged.
- R10: A mode cycle, auto-refresh or self-refresh entry while any bank is open raises `illegal`. It produces no strobe and changes no state.
- R11: After an accepted mode cycle, `mrs_lock` is high for the next LOCK_CLKS-1 samples (one sample by default). Any command other than no-operation or deselect in that window raises `illegal`, produces no strobe and has no effect.
- R12: `cmd_strb`, `illegal` and the R4 fields are valid in the cycle after the edge that captured the pins. Register and bank-state changes appear one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Multiplexed address |
| cmd_strb | output | 10 | One-hot command strobe (bit map in R1, R3) |
| cmd_bank | output | 2 | Bank of the current sample |
| cmd_row | output | 12 | Row address of the current sample |
| cmd_col | output | 9 | Column address of the current sample |
| cmd_a10 | output | 1 | Auto-precharge / all-banks flag |
| illegal | output | 1 | Current sample breaks a legality rule |
| all_idle | output | 1 | No bank holds an open row |
| mrs_lock | output | 1 | Post-mode-cycle lockout active |
| burst_len | output | 3 | Stored burst-length code |
| burst_intlv | output | 1 | Stored burst type, 1 = interleave |
| cas_lat | output | 2 | Stored CAS latency (1 to 3) |
| wr_single | output | 1 | Burst read with single-bit write enabled |
| pasr_area | output | 2 | Self-refresh area: 0 full, 1 half, 2 quarter |

## Verification
On every cycle the assertions check the following. The strobe is one-hot or empty and stays empty while `illegal` is high. A mode cycle or refresh strobe only appears with all banks idle. The lockout follows each mode strobe and blocks every strobe other than no-operation. The stored fields hold still unless their own strobe fired, and never contain a reserved code. Only the bench scenarios can show the rest. Those cover the exact decoding of each pin code and each field value, the CKE-transition cases, and the bank open and close bookkeeping through precharge and auto-precharge. They also show that rejected mode cycles leave the earlier settings intact.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // Strobe bit positions of the one-hot command vector
    localparam int STRB_W  = 10;
    localparam int SB_NOP  = 0;
    localparam int SB_MRS  = 1;
    localparam int SB_EMRS = 2;
    localparam int SB_AREF = 3;
    localparam int SB_SREF = 4;
    localparam int SB_ACT  = 5;
    localparam int SB_RD   = 6;
    localparam int SB_WR   = 7;
    localparam int SB_BST  = 8;
    localparam int SB_PRE  = 9;

    localparam logic [STRB_W-1:0] NOP_MASK  = STRB_W'(1) << SB_NOP;
    localparam logic [STRB_W-1:0] IDLE_MASK = (STRB_W'(1) << SB_MRS)  |
                                              (STRB_W'(1) << SB_EMRS) |
                                              (STRB_W'(1) << SB_AREF) |
                                              (STRB_W'(1) << SB_SREF);

    // Pin code {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        PC_MODE = 3'b000,
        PC_REF  = 3'b001,
        PC_PRE  = 3'b010,
        PC_ACT  = 3'b011,
        PC_WR   = 3'b100,
        PC_RD   = 3'b101,
        PC_BST  = 3'b110,
        PC_NOP  = 3'b111
    } pin_code_e;

    // Stored mode fields
    typedef struct packed {
        logic [2:0] bl;
        logic       bt;
        logic [1:0] cl;
        logic       ws;
        logic [1:0] pasr;
    } mode_fields_t;

    localparam mode_fields_t MODE_RESET = '{bl: 3'b000, bt: 1'b0, cl: 2'd3,
                                            ws: 1'b0, pasr: 2'd0};

    function automatic pin_code_e decode_pins(input logic r, input logic c, input logic w);
        return pin_code_e'({r, c, w});
    endfunction

    function automatic logic bl_ok(input logic [2:0] code);
        return (code[2] == 1'b0) || (code == 3'b111);
    endfunction

    function automatic logic cl_ok(input logic [2:0] code);
        return (code[2] == 1'b0) && (code[1:0] != 2'b00);
    endfunction

    function automatic logic pasr_ok(input logic [2:0] code);
        return (code[2] == 1'b0) && (code[1:0] != 2'b11);
    endfunction

endpackage

// File: rtl/sdcmd_sample.sv
module sdcmd_sample #(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              s_cke,
    output logic              s_cke_prev,
    output logic              s_cs_n,
    output logic              s_ras_n,
    output logic              s_cas_n,
    output logic              s_we_n,
    output logic [BA_W-1:0]   s_ba,
    output logic [ADDR_W-1:0] s_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_cke      <= 1'b1;
            s_cke_prev <= 1'b1;
            s_cs_n     <= 1'b1;
            s_ras_n    <= 1'b1;
            s_cas_n    <= 1'b1;
            s_we_n     <= 1'b1;
            s_ba       <= '0;
            s_addr     <= '0;
        end else begin
            s_cke_prev <= s_cke;
            s_cke      <= cke;
            s_cs_n     <= cs_n;
            s_ras_n    <= ras_n;
            s_cas_n    <= cas_n;
            s_we_n     <= we_n;
            s_ba       <= ba;
            s_addr     <= addr;
        end
    end

endmodule

// File: rtl/sdcmd_classify.sv
module sdcmd_classify
    import sdcmd_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic              s_cke,
    input  logic              s_cke_prev,
    input  logic              s_cs_n,
    input  logic              s_ras_n,
    input  logic              s_cas_n,
    input  logic              s_we_n,
    input  logic [BA_W-1:0]   s_ba,
    input  logic [6:0]        a_lo,
    input  logic              a9,
    input  logic              all_idle,
    input  logic              locked,
    output logic [STRB_W-1:0] strb,
    output logic              illegal,
    output mode_fields_t      fld_new
);

    localparam logic [BA_W-1:0] BA_NORMAL = BA_W'(0);
    localparam logic [BA_W-1:0] BA_EXT    = BA_W'(2);

    pin_code_e         code;
    logic              live;
    logic              ba_rsv;
    logic              field_bad;
    logic              busy_bad;
    logic              lock_bad;
    logic [STRB_W-1:0] cand;

    always_comb begin
        code   = decode_pins(s_ras_n, s_cas_n, s_we_n);
        live   = !s_cs_n && s_cke_prev;
        cand   = '0;
        ba_rsv = 1'b0;
        if (live) begin
            if (!s_cke) begin
                if (code == PC_REF) cand[SB_SREF] = 1'b1;
            end else begin
                unique case (code)
                    PC_MODE: begin
                        if (s_ba == BA_NORMAL)   cand[SB_MRS]  = 1'b1;
                        else if (s_ba == BA_EXT) cand[SB_EMRS] = 1'b1;
                        else                     ba_rsv        = 1'b1;
                    end
                    PC_REF:  cand[SB_AREF] = 1'b1;
                    PC_ACT:  cand[SB_ACT]  = 1'b1;
                    PC_RD:   cand[SB_RD]   = 1'b1;
                    PC_WR:   cand[SB_WR]   = 1'b1;
                    PC_BST:  cand[SB_BST]  = 1'b1;
                    PC_PRE:  cand[SB_PRE]  = 1'b1;
                    default: cand[SB_NOP]  = 1'b1;
                endcase
            end
        end

        field_bad = (cand[SB_MRS]  && (!bl_ok(a_lo[2:0]) || !cl_ok(a_lo[6:4]))) ||
                    (cand[SB_EMRS] && !pasr_ok(a_lo[2:0]));
        busy_bad  = !all_idle && ((cand & IDLE_MASK) != '0);
        lock_bad  = locked && ((cand & ~NOP_MASK) != '0);
        illegal   = ba_rsv || field_bad || busy_bad || lock_bad;
        strb      = illegal ? '0 : cand;

        fld_new.bl   = a_lo[2:0];
        fld_new.bt   = a_lo[3];
        fld_new.cl   = a_lo[5:4];
        fld_new.ws   = a9;
        fld_new.pasr = a_lo[1:0];
    end

endmodule

// File: rtl/sdcmd_mode_regs.sv
module sdcmd_mode_regs
    import sdcmd_pkg::*;
#(
    parameter int LOCK_CLKS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_mode,
    input  logic         set_ext,
    input  mode_fields_t fld_new,
    output mode_fields_t fld,
    output logic         locked
);

    localparam int LK_W = $clog2(LOCK_CLKS + 1);
    localparam logic [LK_W-1:0] LK_LOAD = LK_W'(LOCK_CLKS - 1);

    logic [LK_W-1:0] lk_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fld <= MODE_RESET;
        end else if (set_mode) begin
            fld.bl <= fld_new.bl;
            fld.bt <= fld_new.bt;
            fld.cl <= fld_new.cl;
            fld.ws <= fld_new.ws;
        end else if (set_ext) begin
            fld.pasr <= fld_new.pasr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_cnt <= '0;
        end else if (set_mode || set_ext) begin
            lk_cnt <= LK_LOAD;
        end else if (lk_cnt != '0) begin
            lk_cnt <= lk_cnt - LK_W'(1);
        end
    end

    assign locked = (lk_cnt != '0);

endmodule

// File: rtl/sdcmd_bank_track.sv
module sdcmd_bank_track #(
    parameter int BA_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            do_act,
    input  logic            do_pre,
    input  logic            do_rdwr,
    input  logic [BA_W-1:0] bank,
    input  logic            a10,
    output logic            all_idle
);

    localparam int NUM_BANKS = 1 << BA_W;

    logic [NUM_BANKS-1:0] open_q;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        assign hit = (bank == BA_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[i] <= 1'b0;
            end else if (do_act && hit) begin
                open_q[i] <= 1'b1;
            end else if (do_pre && (a10 || hit)) begin
                open_q[i] <= 1'b0;
            end else if (do_rdwr && a10 && hit) begin
                open_q[i] <= 1'b0;
            end
        end
    end

    assign all_idle = (open_q == '0);

endmodule

// File: rtl/sdcmd_decoder.sv
module sdcmd_decoder
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 10,
    parameter int LOCK_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [STRB_W-1:0] cmd_strb,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ADDR_W-1:0] cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_a10,
    output logic              illegal,
    output logic              all_idle,
    output logic              mrs_lock,
    output logic [2:0]        burst_len,
    output logic              burst_intlv,
    output logic [1:0]        cas_lat,
    output logic              wr_single,
    output logic [1:0]        pasr_area
);

    logic              s_cke, s_cke_prev, s_cs_n, s_ras_n, s_cas_n, s_we_n;
    logic [BA_W-1:0]   s_ba;
    logic [ADDR_W-1:0] s_addr;
    logic [STRB_W-1:0] strb;
    logic              locked;
    mode_fields_t      fld_new;
    mode_fields_t      fld;

    sdcmd_sample #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_sample (
        .clk        (clk),
        .rst        (rst),
        .cke        (cke),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ba         (ba),
        .addr       (addr),
        .s_cke      (s_cke),
        .s_cke_prev (s_cke_prev),
        .s_cs_n     (s_cs_n),
        .s_ras_n    (s_ras_n),
        .s_cas_n    (s_cas_n),
        .s_we_n     (s_we_n),
        .s_ba       (s_ba),
        .s_addr     (s_addr)
    );

    sdcmd_classify #(.BA_W(BA_W)) u_classify (
        .s_cke      (s_cke),
        .s_cke_prev (s_cke_prev),
        .s_cs_n     (s_cs_n),
        .s_ras_n    (s_ras_n),
        .s_cas_n    (s_cas_n),
        .s_we_n     (s_we_n),
        .s_ba       (s_ba),
        .a_lo       (s_addr[6:0]),
        .a9         (s_addr[9]),
        .all_idle   (all_idle),
        .locked     (locked),
        .strb       (strb),
        .illegal    (illegal),
        .fld_new    (fld_new)
    );

    sdcmd_mode_regs #(.LOCK_CLKS(LOCK_CLKS)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .set_mode (strb[SB_MRS]),
        .set_ext  (strb[SB_EMRS]),
        .fld_new  (fld_new),
        .fld      (fld),
        .locked   (locked)
    );

    sdcmd_bank_track #(.BA_W(BA_W)) u_banks (
        .clk      (clk),
        .rst      (rst),
        .do_act   (strb[SB_ACT]),
        .do_pre   (strb[SB_PRE]),
        .do_rdwr  (strb[SB_RD] | strb[SB_WR]),
        .bank     (s_ba),
        .a10      (s_addr[AP_BIT]),
        .all_idle (all_idle)
    );

    assign cmd_strb    = strb;
    assign cmd_bank    = s_ba;
    assign cmd_row     = s_addr;
    assign cmd_col     = s_addr[COL_W-1:0];
    assign cmd_a10     = s_addr[AP_BIT];
    assign mrs_lock    = locked;
    assign burst_len   = fld.bl;
    assign burst_intlv = fld.bt;
    assign cas_lat     = fld.cl;
    assign wr_single   = fld.ws;
    assign pasr_area   = fld.pasr;

endmodule

// File: rtl/sdcmd_decoder_chk.sv
module sdcmd_decoder_chk
    import sdcmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [STRB_W-1:0] cmd_strb,
    input logic              illegal,
    input logic              all_idle,
    input logic              mrs_lock,
    input logic [2:0]        burst_len,
    input logic              burst_intlv,
    input logic [1:0]        cas_lat,
    input logic              wr_single,
    input logic [1:0]        pasr_area
);

    a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_strb));

    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (cmd_strb == '0));

    a_r10_needs_idle: assert property (@(posedge clk) disable iff (rst)
        ((cmd_strb & IDLE_MASK) != '0) |-> all_idle);

    a_r11_lock_follows: assert property (@(posedge clk) disable iff (rst)
        (cmd_strb[SB_MRS] || cmd_strb[SB_EMRS]) |=> mrs_lock);

    a_r11_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        mrs_lock |-> ((cmd_strb & ~NOP_MASK) == '0));

    a_r6_fields_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_strb[SB_MRS] |=> $stable({burst_len, burst_intlv, cas_lat, wr_single}));

    a_r7_area_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_strb[SB_EMRS] |=> $stable(pasr_area));

    a_r9_no_reserved: assert property (@(posedge clk) disable iff (rst)
        (cas_lat != 2'd0) && (pasr_area != 2'd3) && bl_ok(burst_len));

    a_r8_reset_values: assert property (@(posedge clk)
        rst |=> (burst_len == 3'd0 && !burst_intlv && cas_lat == 2'd3 &&
                 !wr_single && pasr_area == 2'd0 && all_idle && !mrs_lock));

endmodule

bind sdcmd_decoder sdcmd_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_strb    (cmd_strb),
    .illegal     (illegal),
    .all_idle    (all_idle),
    .mrs_lock    (mrs_lock),
    .burst_len   (burst_len),
    .burst_intlv (burst_intlv),
    .cas_lat     (cas_lat),
    .wr_single   (wr_single),
    .pasr_area   (pasr_area)
);

// File: tb/sdcmd_decoder_tb.sv
module sdcmd_decoder_tb;

    localparam int LOCK = 2;
    localparam logic [2:0] K_MODE = 3'b000, K_REF = 3'b001, K_PRE = 3'b010,
                           K_ACT  = 3'b011, K_WR  = 3'b100, K_RD  = 3'b101,
                           K_BST  = 3'b110, K_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [9:0]  cmd_strb;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_row;
    logic [8:0]  cmd_col;
    logic        cmd_a10, illegal, all_idle, mrs_lock;
    logic [2:0]  burst_len;
    logic        burst_intlv, wr_single;
    logic [1:0]  cas_lat, pasr_area;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state
    logic [3:0] m_open;
    logic [2:0] m_bl;
    logic       m_bt, m_ws, m_ckeprev;
    logic [1:0] m_cl, m_pasr;
    int         m_lock;

    always #5 clk = ~clk;

    sdcmd_decoder u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_strb(cmd_strb), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_a10(cmd_a10), .illegal(illegal),
        .all_idle(all_idle), .mrs_lock(mrs_lock), .burst_len(burst_len),
        .burst_intlv(burst_intlv), .cas_lat(cas_lat), .wr_single(wr_single),
        .pasr_area(pasr_area)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit bl_valid(input logic [2:0] c);
        return (c <= 3'd3) || (c == 3'd7);
    endfunction

    function automatic bit cl_valid(input logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd3);
    endfunction

    task automatic model_reset();
        m_open = '0; m_bl = 3'd0; m_bt = 1'b0; m_cl = 2'd3; m_ws = 1'b0;
        m_pasr = 2'd0; m_lock = 0; m_ckeprev = 1'b1;
    endtask

    // One sampled cycle: drive, wait for capture, check, update reference
    task automatic step(input logic k, input logic [2:0] code, input logic cs,
                        input logic [1:0] b, input logic [11:0] a, input string tag);
        logic [9:0] cand;
        logic [9:0] e_strb;
        bit rsv, fbad, busy, lockb, e_ill;
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
        cand = '0; rsv = 0;
        if (!cs && m_ckeprev) begin
            if (!k) begin
                if (code == K_REF) cand[4] = 1'b1;
            end else begin
                case (code)
                    K_MODE: if (b == 2'd0) cand[1] = 1'b1;
                            else if (b == 2'd2) cand[2] = 1'b1;
                            else rsv = 1;
                    K_REF:  cand[3] = 1'b1;
                    K_ACT:  cand[5] = 1'b1;
                    K_RD:   cand[6] = 1'b1;
                    K_WR:   cand[7] = 1'b1;
                    K_BST:  cand[8] = 1'b1;
                    K_PRE:  cand[9] = 1'b1;
                    default: cand[0] = 1'b1;
                endcase
            end
        end
        fbad  = (cand[1] && (!bl_valid(a[2:0]) || !cl_valid(a[6:4]))) ||
                (cand[2] && (a[2:0] > 3'd2));
        busy  = (m_open != 0) && (cand[1] || cand[2] || cand[3] || cand[4]);
        lockb = (m_lock > 0) && ((cand & 10'h3FE) != 0);
        e_ill = rsv || fbad || busy || lockb;
        e_strb = e_ill ? 10'd0 : cand;

        @(posedge clk);
        @(negedge clk);
        chk(cmd_strb == e_strb, tag, "strobe", 32'(cmd_strb), 32'(e_strb));
        chk(illegal == e_ill, tag, "illegal", 32'(illegal), 32'(e_ill));
        chk(all_idle == (m_open == 0), tag, "all_idle", 32'(all_idle), 32'(m_open == 0));
        chk(mrs_lock == (m_lock > 0), tag, "mrs_lock", 32'(mrs_lock), 32'(m_lock > 0));
        chk(burst_len == m_bl, tag, "burst_len", 32'(burst_len), 32'(m_bl));
        chk(burst_intlv == m_bt, tag, "burst_intlv", 32'(burst_intlv), 32'(m_bt));
        chk(cas_lat == m_cl, tag, "cas_lat", 32'(cas_lat), 32'(m_cl));
        chk(wr_single == m_ws, tag, "wr_single", 32'(wr_single), 32'(m_ws));
        chk(pasr_area == m_pasr, tag, "pasr_area", 32'(pasr_area), 32'(m_pasr));

        if (e_strb[1]) begin
            m_bl = a[2:0]; m_bt = a[3]; m_cl = a[5:4]; m_ws = a[9];
        end
        if (e_strb[2]) m_pasr = a[1:0];
        if (e_strb[1] || e_strb[2]) m_lock = LOCK - 1;
        else if (m_lock > 0) m_lock--;
        if (e_strb[5]) m_open[b] = 1'b1;
        if (e_strb[9]) begin
            if (a[10]) m_open = '0;
            else m_open[b] = 1'b0;
        end
        if ((e_strb[6] || e_strb[7]) && a[10]) m_open[b] = 1'b0;
        m_ckeprev = k;
    endtask

    task automatic nop(input string tag);
        step(1'b1, K_NOP, 1'b0, 2'd0, 12'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] ra;
        logic [2:0]  rc;
        int          sel;
        rst = 1'b1; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1;
        we_n = 1'b1; ba = '0; addr = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        chk(burst_len == 3'd0, "R8", "burst_len", 32'(burst_len), 0);
        chk(burst_intlv == 1'b0, "R8", "burst_intlv", 32'(burst_intlv), 0);
        chk(cas_lat == 2'd3, "R8", "cas_lat", 32'(cas_lat), 3);
        chk(wr_single == 1'b0, "R8", "wr_single", 32'(wr_single), 0);
        chk(pasr_area == 2'd0, "R8", "pasr_area", 32'(pasr_area), 0);
        chk(all_idle == 1'b1, "R8", "all_idle", 32'(all_idle), 1);
        chk(mrs_lock == 1'b0, "R8", "mrs_lock", 32'(mrs_lock), 0);
        chk(cmd_strb == 10'd0, "R8", "strobe", 32'(cmd_strb), 0);

        // R1 / R2: no-operation and deselect
        nop("R1");
        step(1'b1, K_ACT, 1'b1, 2'd1, 12'h123, "R2");

        // R6: mode cycle BL=8, interleave, CL=2, single write
        step(1'b1, K_MODE, 1'b0, 2'd0, 12'h22B, "R6");
        nop("R6");
        nop("R6");

        // R11: command right after a mode cycle is rejected
        step(1'b1, K_MODE, 1'b0, 2'd0, 12'h031, "R11");
        step(1'b1, K_ACT, 1'b0, 2'd2, 12'h055, "R11");
        step(1'b1, K_ACT, 1'b0, 2'd2, 12'h055, "R11");
        step(1'b1, K_PRE, 1'b0, 2'd0, 12'h400, "R11");

        // R7: extended cycle selects quarter area
        step(1'b1, K_MODE, 1'b0, 2'd2, 12'h002, "R7");
        nop("R7");
        nop("R7");

        // R9: reserved codes
        step(1'b1, K_MODE, 1'b0, 2'd0, 12'h034, "R9");
        step(1'b1, K_MODE, 1'b0, 2'd0, 12'h001, "R9");
        step(1'b1, K_MODE, 1'b0, 2'd0, 12'h041, "R9");
        step(1'b1, K_MODE, 1'b0, 2'd1, 12'h000, "R9");
        step(1'b1, K_MODE, 1'b0, 2'd3, 12'h000, "R9");
        step(1'b1, K_MODE, 1'b0, 2'd2, 12'h003, "R9");
        nop("R9");

        // R4: activate fields
        step(1'b1, K_ACT, 1'b0, 2'd1, 12'hABC, "R4");
        chk(cmd_row == 12'hABC, "R4", "cmd_row", 32'(cmd_row), 32'hABC);
        chk(cmd_bank == 2'd1, "R4", "cmd_bank", 32'(cmd_bank), 1);
        nop("R5");

        // R10: mode / refresh with an open bank
        step(1'b1, K_MODE, 1'b0, 2'd0, 12'h032, "R10");
        step(1'b1, K_REF, 1'b0, 2'd0, 12'h000, "R10");
        step(1'b0, K_REF, 1'b0, 2'd0, 12'h000, "R10");
        step(1'b1, K_NOP, 1'b0, 2'd0, 12'h000, "R2");
        nop("R10");

        // R4 / R5: read with auto-precharge closes bank 1
        step(1'b1, K_RD, 1'b0, 2'd1, 12'h5A5, "R4");
        chk(cmd_col == 9'h1A5, "R4", "cmd_col", 32'(cmd_col), 32'h1A5);
        chk(cmd_a10 == 1'b1, "R4", "cmd_a10", 32'(cmd_a10), 1);
        nop("R5");

        // R5: single-bank and all-bank precharge
        step(1'b1, K_ACT, 1'b0, 2'd0, 12'h010, "R5");
        step(1'b1, K_ACT, 1'b0, 2'd3, 12'h020, "R5");
        step(1'b1, K_PRE, 1'b0, 2'd0, 12'h000, "R5");
        nop("R5");
        step(1'b1, K_WR, 1'b0, 2'd3, 12'h00F, "R5");
        step(1'b1, K_PRE, 1'b0, 2'd2, 12'h400, "R5");
        nop("R5");

        // R1 / R3: refresh and self-refresh entry, power-down entry
        step(1'b1, K_REF, 1'b0, 2'd0, 12'h000, "R1");
        step(1'b1, K_BST, 1'b0, 2'd0, 12'h000, "R1");
        step(1'b0, K_REF, 1'b0, 2'd0, 12'h000, "R3");
        step(1'b0, K_REF, 1'b0, 2'd0, 12'h000, "R3");
        step(1'b1, K_ACT, 1'b0, 2'd0, 12'h000, "R3");
        step(1'b0, K_ACT, 1'b0, 2'd0, 12'h000, "R3");
        step(1'b1, K_NOP, 1'b0, 2'd0, 12'h000, "R2");
        nop("R3");

        // R12: seeded random traffic
        void'($urandom(32'h5D0C_0A11));
        for (int i = 0; i < 4000; i++) begin
            sel = int'($urandom % 16);
            ra  = 12'($urandom);
            case (sel)
                0, 1: rc = K_MODE;
                2:    rc = K_REF;
                3, 4: rc = K_ACT;
                5:    rc = K_RD;
                6:    rc = K_WR;
                7:    rc = K_BST;
                8, 9, 10: rc = K_PRE;
                default: rc = K_NOP;
            endcase
            if (rc == K_MODE && ($urandom % 2 == 0)) begin
                logic [2:0] bsel;
                bsel = 3'($urandom % 5);
                ra = {2'b00, 1'($urandom), 2'b00, 3'(1 + $urandom % 3),
                      1'($urandom), (bsel == 3'd4) ? 3'd7 : bsel};
            end
            if (rc == K_PRE && ($urandom % 2 == 0)) ra[10] = 1'b1;
            step(($urandom % 16) != 0, rc, ($urandom % 8) == 0,
                 2'($urandom), ra, "R12");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule